// File: doc/BRIEF.md
# Low-Switching Sequential Multiplier

This block multiplies two unsigned K-bit operands with one adder over K cycles. It is built to keep toggling low. A start pulse while the block is idle loads both operands. The block then works through one multiplier bit per cycle, from least to most significant. After the last bit it raises a one-cycle ready flag with the 2K-bit product. The product stays on the output until the next accepted start.

The multiplicand goes straight into one adder input and is held for the whole operation. The adder's other input is a feeder register. A second register, the bypass register, holds the partial product whenever the next multiplier bit is zero. On such a bit the adder sees no change on either input. A lookahead on the following multiplier bit decides which of the two registers takes each new partial product.

The low half of the product is never shifted. Each resolved bit is written once, in place, into its own position. A one-hot ring counter enables that write. The ring counter is built from groups of flops, and a group is clocked only while its token is inside the group or about to enter it. Clock gating is modelled as synchronous enables.

Top module: `lowsw_mult`

## Requirements
- R1: After a synchronous active-low reset, ready is 0, busy is 0 and product is all zeros.
- R2: A start pulse sampled while busy is 0 loads both operands, and busy reads 1 from the next cycle on.
- R3: When start is accepted at clock edge 0, ready is 1 for exactly one cycle, the cycle after edge K. In that same cycle busy reads 0.
- R4: When ready is 1, product equals the unsigned product of the two loaded operands. It keeps that value until the next start is accepted.
- R5: A start pulse sampled while busy is 1 is ignored. The running operation keeps its operands, its timing and its result.
- R6: On a step whose multiplier bit is zero, the feeder register (the adder's variable input) and the multiplicand both hold their values. Multiplier values with sparse and alternating bit patterns still yield the exact product.
- R7: The position counter is one-hot while busy and zero while idle. It advances one place per cycle, so busy lasts exactly K cycles.
- R8: The corner operands 0, 1 and all-ones, in every pairing, give the exact product.
- R9: A start pulse in the cycle where ready is 1 is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation; honoured only while busy is 0 |
| op_a | input | K | Multiplicand, sampled on an accepted start |
| op_b | input | K | Multiplier, sampled on an accepted start |
| busy | output | 1 | An operation is in progress |
| ready | output | 1 | One-cycle flag: product is valid |
| product | output | 2K | Unsigned product, {upper half, lower half} |

## Verification
The hardest cases to reach from the ports are a start that arrives at the edge where an operation finishes, and a start that arrives in the cycle right after it. The first must be ignored and the second must be accepted. The bench targets both. It waits on its own model until that model shows the ready cycle, then drives start in that cycle (R9). It also holds start high through the middle of a run with different operands on the inputs, then checks that the first result is unchanged (R5). Sparse, alternating and all-zero multiplier patterns drive long runs of zero bits. Over those runs the checker watches that the feeder register holds its value.

// File: rtl/lowsw_pkg.sv
// Package: shared helpers for the low-switching multiplier.
// Assumes: integer arguments are positive.
package lowsw_pkg;
    // Integer ceiling division, used to size the counter groups.
    function automatic int ceil_div(input int n, input int d);
        return (n + d - 1) / d;
    endfunction
endpackage

// File: rtl/lowsw_ring.sv
// Module: lowsw_ring
// One-hot position counter. A single 1 moves from bit 0 toward bit K-1,
// one place per cycle, and then leaves the vector (counter becomes zero).
// The flops are split into groups of GRP bits. A group's register is
// enabled only while its token is inside the group, about to enter it, or
// when a load occurs. This stands in for clock gating.
// Assumes: load is asserted only while the counter is zero; GRP >= 1.
module lowsw_ring
    import lowsw_pkg::*;
#(
    parameter int K   = 24,
    parameter int GRP = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    output logic [K-1:0] ring
);
    localparam int NGRP = ceil_div(K, GRP);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO = g * GRP;
        localparam int W  = ((K - LO) < GRP) ? (K - LO) : GRP;

        logic [W-1:0] seg;
        logic [W:0]   ext;
        logic         cin;
        logic         grp_en;

        if (g == 0) begin : g_first
            assign cin = 1'b0;
        end else begin : g_rest
            assign cin = ring[LO-1];
        end

        assign ext    = {seg, cin};
        assign grp_en = load | (|seg) | cin;

        // Group register: move the token one place, or load the initial token.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg <= '0;
            end else if (grp_en) begin
                if (load) begin
                    seg <= (g == 0) ? W'(1) : '0;
                end else begin
                    seg <= ext[W-1:0];
                end
            end
        end

        assign ring[LO +: W] = seg;
    end
endmodule

// File: rtl/lowsw_pp_core.sv
// Module: lowsw_pp_core
// Partial-product engine. The multiplicand feeds the adder directly. The
// other adder input is the feeder register. A partial product that must go
// through an add next cycle is parked in the feeder register; one that must
// not is parked in the bypass register. On a zero bit both adder inputs
// stay constant.
// Assumes: a_op is constant while step is high; next_bit is 0 on the
// last step, so the final upper half ends in the bypass register.
module lowsw_pp_core #(
    parameter int K = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         first_bit,
    input  logic         next_bit,
    input  logic [K-1:0] a_op,
    output logic         res_lsb,
    output logic [K-1:0] feeder_q,
    output logic [K-1:0] bypass_q
);
    logic         use_add_q;
    logic [K:0]   sum;
    logic [K:0]   res;
    logic [K-1:0] new_pp;
    logic         wr_feed;
    logic         wr_byp;

    // Adder: the multiplicand is wired straight to one input, with no select.
    assign sum = {1'b0, feeder_q} + {1'b0, a_op};

    // Result of this step: the sum for a one bit, the held value for a zero bit.
    always_comb begin
        res = use_add_q ? sum : {1'b0, bypass_q};
    end

    assign new_pp  = res[K:1];
    assign res_lsb = res[0];

    // Steering from the lookahead bit: a 1 writes the feeder, a 0 writes the bypass.
    assign wr_feed = step & next_bit;
    assign wr_byp  = step & ~next_bit;

    // Feeder register: written only when the next step will add.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            feeder_q <= '0;
        end else if (load && first_bit) begin
            feeder_q <= '0;
        end else if (wr_feed) begin
            feeder_q <= new_pp;
        end
    end

    // Bypass register: written only when the next step will skip the add.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bypass_q <= '0;
        end else if (load && !first_bit) begin
            bypass_q <= '0;
        end else if (wr_byp) begin
            bypass_q <= new_pp;
        end
    end

    // Source flag: which register holds the live partial product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            use_add_q <= 1'b0;
        end else if (load) begin
            use_add_q <= first_bit;
        end else if (step) begin
            use_add_q <= next_bit;
        end
    end
endmodule

// File: rtl/lowsw_low_bank.sv
// Module: lowsw_low_bank
// Lower product half. Each position is written once, in place, when its
// one-hot select is high, and is never shifted.
// Assumes: wr_sel has at most one bit set.
module lowsw_low_bank #(
    parameter int K = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [K-1:0] wr_sel,
    input  logic         bit_in,
    output logic [K-1:0] low_q
);
    for (genvar i = 0; i < K; i++) begin : g_bit
        // Position i: capture the bit resolved in step i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                low_q[i] <= 1'b0;
            end else if (wr_sel[i]) begin
                low_q[i] <= bit_in;
            end
        end
    end
endmodule

// File: rtl/lowsw_mult.sv
// Module: lowsw_mult (top)
// Unsigned K x K sequential multiplier built for low toggling. It loads
// the operands on a start pulse while idle, processes one multiplier bit
// per cycle for K cycles, then pulses ready with the 2K-bit product.
// Assumes: K >= 2; start pulses during busy are dropped.
module lowsw_mult #(
    parameter int K        = 24,
    parameter int RING_GRP = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [K-1:0]   op_a,
    input  logic [K-1:0]   op_b,
    output logic           busy,
    output logic           ready,
    output logic [2*K-1:0] product
);
    logic [K-1:0] a_reg;
    logic [K-1:0] b_reg;
    logic [K-1:0] ring;
    logic [K-1:0] feeder_q;
    logic [K-1:0] bypass_q;
    logic [K-1:0] low_q;
    logic         accept;
    logic         next_bit;
    logic         res_lsb;

    assign busy   = |ring;
    assign accept = start & ~busy;

    // Lookahead: the multiplier bit used in the step after the current one.
    assign next_bit = |(b_reg[K-1:1] & ring[K-2:0]);

    // Operand registers: loaded only on an accepted start, then held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_reg <= '0;
            b_reg <= '0;
        end else if (accept) begin
            a_reg <= op_a;
            b_reg <= op_b;
        end
    end

    // Ready flag: raised in the cycle after the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b0;
        end else begin
            ready <= ring[K-1];
        end
    end

    lowsw_ring #(.K(K), .GRP(RING_GRP)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .ring  (ring)
    );

    lowsw_pp_core #(.K(K)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .step      (busy),
        .first_bit (op_b[0]),
        .next_bit  (next_bit),
        .a_op      (a_reg),
        .res_lsb   (res_lsb),
        .feeder_q  (feeder_q),
        .bypass_q  (bypass_q)
    );

    lowsw_low_bank #(.K(K)) u_low (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (ring),
        .bit_in (res_lsb),
        .low_q  (low_q)
    );

    assign product = {bypass_q, low_q};
endmodule

// File: rtl/lowsw_mult_chk.sv
// Module: lowsw_mult_chk
// Property checker for lowsw_mult, attached with bind below.
// Assumes: the signals are connected to the top module's nets of the same name.
module lowsw_mult_chk #(
    parameter int K = 24
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           ready,
    input logic [K-1:0]   ring,
    input logic           next_bit,
    input logic [K-1:0]   feeder_q,
    input logic [K-1:0]   a_reg,
    input logic [K-1:0]   b_reg,
    input logic [2*K-1:0] product
);
    localparam int CW = $clog2(K + 1) + 1;

    logic [CW-1:0]  cnt;
    logic [2*K-1:0] full;

    assign full = {{K{1'b0}}, a_reg} * {{K{1'b0}}, b_reg};

    // Cycle counter since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start && !busy) begin
            cnt <= '0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ring)); // R7
    AST_RING_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) (busy && !ring[K-1]) |=> (ring == ($past(ring) << 1))); // R7
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n) ready |=> !ready); // R3
    AST_READY_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) ready |-> (cnt == CW'(K) && !busy)); // R3
    AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (!rst_n) ready |-> (product == full)); // R4
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) busy |=> !ring[0]); // R5
    AST_OPERAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(a_reg)); // R5
    AST_FEEDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (busy && !next_bit) |=> $stable(feeder_q)); // R6
endmodule

bind lowsw_mult lowsw_mult_chk #(.K(K)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .ready    (ready),
    .ring     (ring),
    .next_bit (next_bit),
    .feeder_q (feeder_q),
    .a_reg    (a_reg),
    .b_reg    (b_reg),
    .product  (product)
);

// File: tb/lowsw_mult_tb.sv
// Bench for lowsw_mult: a behavioural model, updated on each rising edge,
// is compared with the outputs on every falling edge.
module lowsw_mult_tb;
    localparam int K  = 24;
    localparam int TK = 2 * K;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [K-1:0]  op_a = '0;
    logic [K-1:0]  op_b = '0;
    logic          busy;
    logic          ready;
    logic [TK-1:0] product;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    chk_en = 1'b0;
    string tag = "R4";

    logic          m_busy = 1'b0;
    logic          m_rdy = 1'b0;
    logic          m_pv = 1'b1;
    int            m_cnt = 0;
    logic [TK-1:0] m_exp = '0;
    logic [TK-1:0] m_prod = '0;

    lowsw_mult #(.K(K)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_a    (op_a),
        .op_b    (op_b),
        .busy    (busy),
        .ready   (ready),
        .product (product)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", what, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Reference model: a start while idle begins a K-cycle run.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_cnt = 0; m_rdy = 1'b0; m_pv = 1'b1; m_prod = '0;
        end else begin
            m_rdy = 1'b0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == K) begin
                    m_busy = 1'b0; m_rdy = 1'b1; m_prod = m_exp; m_pv = 1'b1;
                end
            end else if (start) begin
                m_busy = 1'b1; m_cnt = 0; m_pv = 1'b0;
                m_exp = TK'(op_a) * TK'(op_b);
            end
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (chk_en) begin
            chk(ready === m_rdy, "R3 ready", 64'(ready), 64'(m_rdy));
            chk(busy === m_busy, "R2 busy", 64'(busy), 64'(m_busy));
            if (m_pv) chk(product === m_prod, {tag, " product"}, 64'(product), 64'(m_prod));
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            report();
        end
    end

    task automatic go(input logic [K-1:0] a, input logic [K-1:0] b, input string t);
        while (m_busy) @(negedge clk);
        tag = t; op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!m_rdy) @(negedge clk);
    endtask

    task automatic run(input logic [K-1:0] a, input logic [K-1:0] b, input string t);
        go(a, b, t);
        wait_done();
        @(negedge clk);
    endtask

    initial begin
        logic [K-1:0] ones;
        ones = '1;
        repeat (3) @(negedge clk);
        chk(ready === 1'b0, "R1 ready", 64'(ready), 64'd0);
        chk(busy === 1'b0, "R1 busy", 64'(busy), 64'd0);
        chk(product === '0, "R1 product", 64'(product), 64'd0);
        rst_n = 1'b1;
        chk_en = 1'b1;
        @(negedge clk);

        // R8: corner operands in every pairing
        run('0, '0, "R8");   run('0, ones, "R8"); run(ones, '0, "R8");
        run(K'(1), K'(1), "R8"); run(K'(1), ones, "R8"); run(ones, K'(1), "R8");
        run(ones, ones, "R8");

        // R6: long runs of zero multiplier bits and alternating patterns
        run(ones, K'(24'h800001), "R6");
        run(K'(24'h123457), K'(24'h555555), "R6");
        run(K'(24'hABCDEF), K'(24'h000100), "R6");
        run(ones, K'(24'h800000), "R6");

        // R7: busy lasts exactly K cycles
        begin
            int nb;
            nb = 0;
            go(K'(24'h00F00F), K'(24'hF0F0F0), "R7");
            while (!ready) begin
                if (busy) nb++;
                @(negedge clk);
            end
            chk(nb == K, "R7 busy length", 64'(nb), 64'(K));
            @(negedge clk);
        end

        // R5: start held high mid-run with other operands is ignored
        go(K'(24'h3A5C71), K'(24'h0F1E2D), "R5");
        repeat (4) @(negedge clk);
        op_a = K'(24'h777777); op_b = K'(24'h111111); start = 1'b1;
        repeat (10) @(negedge clk);
        start = 1'b0;
        wait_done();
        @(negedge clk);

        // R9: start in the ready cycle is accepted
        go(K'(24'h00ABCD), K'(24'h00DCBA), "R9");
        wait_done();
        tag = "R9"; op_a = K'(24'hFEDCBA); op_b = K'(24'h13579B); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R9 restart busy", 64'(busy), 64'd1);
        wait_done();
        @(negedge clk);

        // R4: random operands
        for (int i = 0; i < 150; i++) begin
            run(K'($urandom), K'($urandom), "R4");
        end

        repeat (3) @(negedge clk);
        report();
    end
endmodule